// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block runs one Serial Wire Debug register transaction at a time from the host side of the wire. A caller hands it a request: whether the access targets an access port or the debug port, read or write, a two-bit register address, write data and an idle-cycle count. The engine builds the 8-bit request packet with its parity bit, shifts it out, releases the data line for the turnaround, samples the target's 3-bit acknowledge and, when the acknowledge is OK, moves 32 data bits and a parity bit in the required direction. It then returns a status code and any read data.

The data line is split into `swdio_out`, `swdio_oe` and `swdio_in`, so the pad's tri-state buffer sits outside the block. `swclk` is derived from the system clock. Its half-period is `clk_div + 1` system cycles, and it rests low between transactions. Requests come in over a valid/ready handshake. `req_ready` is high only while the engine is idle with no result outstanding, so a request is taken on the first cycle in which `req_valid` and `req_ready` are both high. The result goes out over a second valid/ready handshake. While `rsp_ready` is low, `rsp_valid`, `rsp_status` and `rsp_rdata` hold their values and no new request is taken.

Top module: `swd_host_engine`

## Requirements
- R1: Each request packet is 8 wire bits, sent first bit first in this order: 1, AP-select, read flag, addr[0], addr[1], parity, 0, 1. The AP-select bit is 1 for an access-port access and the read flag is 1 for a read.
- R2: The parity bit of the request packet is the XOR of AP-select, the read flag, addr[0] and addr[1].
- R3: The host holds `swdio_oe` low in the turnaround slot after the packet, in the three acknowledge slots, in the 33 read-data slots and in the turnaround slot after read data. Between transactions it drives SWDIO low with `swdio_oe` high.
- R4: The acknowledge is read first bit first. 3'b001 gives status 0 (OK), 3'b010 gives status 1 (WAIT), 3'b100 gives status 2 (FAULT), and any other value gives status 3 (protocol error). A non-OK acknowledge is followed by one released turnaround slot and then the end of the transaction, for 13 SWCLK cycles in total.
- R5: On a read with an OK acknowledge, 32 data bits are sampled first bit first and returned on `rsp_rdata`. If the 33rd bit is not the XOR of those 32 bits, the status is 4 (data parity error).
- R6: On a write with an OK acknowledge, the host leaves one turnaround slot released, then drives the 32 data bits first bit first, followed by their even parity.
- R7: After an access-port access with an OK acknowledge, the host appends `req_idle` extra SWCLK cycles with SWDIO driven low. A debug-port access, a non-OK acknowledge or `req_idle` = 0 adds none, so a DP access with an OK acknowledge takes 46 SWCLK cycles.
- R8: SWCLK stays low while the engine is idle, and each of its half-periods lasts `clk_div + 1` system clock cycles. The host changes SWDIO only when SWCLK falls or when a request is accepted, and it samples SWDIO just before SWCLK rises.
- R9: `req_ready` and `rsp_valid` are never high together. While `rsp_ready` is low, the response and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | SWCLK half-period minus one, in system cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_ap | input | 1 | 1 = access-port access, 0 = debug-port access |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits A[3:2] |
| req_wdata | input | 32 | Write data |
| req_idle | input | IDLE_W | Idle cycles to append after an AP access |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Caller takes the result |
| rsp_status | output | 3 | 0 OK, 1 WAIT, 2 FAULT, 3 protocol error, 4 data parity error |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| swclk | output | 1 | Serial wire clock |
| swdio_out | output | 1 | Value driven onto SWDIO |
| swdio_oe | output | 1 | Enable for the host's SWDIO driver |
| swdio_in | input | 1 | Value sampled from the SWDIO pad |

## Verification
A fault in the phase sequencer shows up as a wrong number of SWCLK cycles per transaction, or as the host driving SWDIO in a slot where the target drives it. The bench sees either within the transaction in which the fault occurs, because it counts SWCLK edges and records `swdio_oe` at every rising edge. A bad packet or data shifter shows up as a wrong wire bit in the slot where the bit is sent. A stale acknowledge or data-parity result shows up as a wrong `rsp_status` on the response that ends the same transaction.

// File: rtl/swd_eng_pkg.sv
package swd_eng_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    XS_OK     = 3'd0,
    XS_WAIT   = 3'd1,
    XS_FAULT  = 3'd2,
    XS_PROTO  = 3'd3,
    XS_PARITY = 3'd4
  } xfer_status_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_REQ,
    PH_TRN1,
    PH_ACK,
    PH_RDATA,
    PH_TRN2,
    PH_WDATA,
    PH_GAP,
    PH_FIN,
    PH_RESP
  } phase_e;

  localparam logic [2:0] ACK_CODE_OK    = 3'b001;
  localparam logic [2:0] ACK_CODE_WAIT  = 3'b010;
  localparam logic [2:0] ACK_CODE_FAULT = 3'b100;
endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = run && (cnt_q >= div);
  assign rise_tick = wrap && !sck;
  assign fall_tick = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck   <= ~sck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  sck_rest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);
endmodule

// File: rtl/swd_req_pkt.sv
module swd_req_pkt (
  input  logic       ap,
  input  logic       rd,
  input  logic [1:0] addr,
  output logic [7:0] pkt
);
  logic par;
  // R2: even parity over the four variable packet bits
  assign par = ap ^ rd ^ addr[0] ^ addr[1];
  // R1: index 0 leaves the wire first
  assign pkt = {1'b1, 1'b0, par, addr[1], addr[0], rd, ap, 1'b1};
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_eng_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic              req_read,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [IDLE_W-1:0] req_idle,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_status,
  output logic [31:0]       rsp_rdata,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);
  localparam int unsigned CNT_W = (IDLE_W > 6) ? IDLE_W : 6;
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(WORD_W);

  phase_e             ph_q;
  logic [CNT_W-1:0]   bit_q;
  logic               ap_q, rd_q;
  logic [7:0]         pkt_q, pkt_c;
  logic [31:0]        wdata_q, rdata_q;
  logic [IDLE_W-1:0]  idle_q;
  logic [1:0]         ack_lo_q;
  xfer_status_e       status_q;
  logic               out_q, oe_q;
  logic               drv_out, drv_oe;
  logic               run, rise_tick, fall_tick;
  logic               gap_wanted;
  logic [2:0]         ack_full;

  swd_req_pkt u_pkt (
    .ap   (req_ap),
    .rd   (req_read),
    .addr (req_addr),
    .pkt  (pkt_c)
  );

  assign run = (ph_q != PH_IDLE) && (ph_q != PH_RESP);

  swd_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .div       (clk_div),
    .sck       (swclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  assign gap_wanted = ap_q && (idle_q != '0);
  assign ack_full   = {swdio_in, ack_lo_q};

  // Line drive for the slot that begins at the next falling edge
  always_comb begin
    drv_out = 1'b0;
    drv_oe  = 1'b1;
    case (ph_q)
      PH_REQ:   drv_out = pkt_q[bit_q[2:0]];
      PH_TRN1, PH_ACK, PH_RDATA, PH_TRN2: drv_oe = 1'b0;
      PH_WDATA: drv_out = (bit_q == LAST_DATA) ? ^wdata_q : wdata_q[bit_q[4:0]];
      default:  drv_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      bit_q    <= '0;
      ap_q     <= 1'b0;
      rd_q     <= 1'b0;
      pkt_q    <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      idle_q   <= '0;
      ack_lo_q <= '0;
      status_q <= XS_OK;
      out_q    <= 1'b0;
      oe_q     <= 1'b1;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (req_valid) begin
            ph_q     <= PH_REQ;
            bit_q    <= '0;
            ap_q     <= req_ap;
            rd_q     <= req_read;
            pkt_q    <= pkt_c;
            wdata_q  <= req_wdata;
            idle_q   <= req_idle;
            rdata_q  <= '0;
            status_q <= XS_OK;
            out_q    <= pkt_c[0];
            oe_q     <= 1'b1;
          end
        end
        PH_RESP: if (rsp_ready) ph_q <= PH_IDLE;
        PH_FIN:  if (fall_tick) ph_q <= PH_RESP;
        default: begin
          if (rise_tick) begin
            bit_q <= bit_q + 1'b1;
            case (ph_q)
              PH_REQ: if (bit_q == CNT_W'(7)) begin
                ph_q  <= PH_TRN1;
                bit_q <= '0;
              end
              PH_TRN1: begin
                ph_q  <= PH_ACK;
                bit_q <= '0;
              end
              PH_ACK: begin
                if (bit_q[1:0] != 2'd2) begin
                  ack_lo_q[bit_q[0]] <= swdio_in;
                end else begin
                  bit_q <= '0;
                  case (ack_full)
                    ACK_CODE_OK:    ph_q <= rd_q ? PH_RDATA : PH_TRN2;
                    ACK_CODE_WAIT:  begin ph_q <= PH_TRN2; status_q <= XS_WAIT;  end
                    ACK_CODE_FAULT: begin ph_q <= PH_TRN2; status_q <= XS_FAULT; end
                    default:        begin ph_q <= PH_TRN2; status_q <= XS_PROTO; end
                  endcase
                end
              end
              PH_RDATA: begin
                if (bit_q == LAST_DATA) begin
                  ph_q  <= PH_TRN2;
                  bit_q <= '0;
                  if ((^rdata_q) != swdio_in) status_q <= XS_PARITY;
                end else begin
                  rdata_q[bit_q[4:0]] <= swdio_in;
                end
              end
              PH_TRN2: begin
                bit_q <= '0;
                if (status_q != XS_OK && status_q != XS_PARITY) ph_q <= PH_FIN;
                else if (!rd_q)                                 ph_q <= PH_WDATA;
                else if (gap_wanted)                            ph_q <= PH_GAP;
                else                                            ph_q <= PH_FIN;
              end
              PH_WDATA: if (bit_q == LAST_DATA) begin
                bit_q <= '0;
                ph_q  <= gap_wanted ? PH_GAP : PH_FIN;
              end
              PH_GAP: if (bit_q == CNT_W'(idle_q) - 1'b1) begin
                bit_q <= '0;
                ph_q  <= PH_FIN;
              end
              default: ph_q <= PH_FIN;
            endcase
          end
        end
      endcase
      if (fall_tick) begin
        out_q <= drv_out;
        oe_q  <= drv_oe;
      end
    end
  end

  assign req_ready  = (ph_q == PH_IDLE);
  assign rsp_valid  = (ph_q == PH_RESP);
  assign rsp_status = status_q;
  assign rsp_rdata  = rdata_q;
  assign swdio_out  = out_q;
  assign swdio_oe   = oe_q;

  // R9
  hs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_rdata));

  // R3
  target_slots_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACK || ph_q == PH_RDATA) |-> !swdio_oe);

  // R8
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(swdio_out) && $stable(swdio_oe)) |-> ($fell(swclk) || $fell(req_ready)));

  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status <= 3'd4);
endmodule

// File: tb/sim_swd_host_engine.sv
`timescale 1ns/1ps
module sim_swd_host_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  clk_div = 8'd1;
  logic        req_valid = 1'b0, req_ap = 1'b0, req_read = 1'b0;
  logic [1:0]  req_addr = 2'b00;
  logic [31:0] req_wdata = '0;
  logic [7:0]  req_idle = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, swclk, swdio_out, swdio_oe, swdio_in;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_rdata;

  swd_host_engine u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_ap(req_ap),
    .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_idle(req_idle), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .swclk(swclk),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  // Target model
  int          slot = 0;
  int          base = 0;
  logic        cap_out [0:63];
  logic        cap_oe  [0:63];
  logic        tgt_oe = 1'b0, tgt_out = 1'b0;
  logic [2:0]  t_ack = 3'b001;
  logic        t_rd = 1'b0, t_bad = 1'b0;
  logic [31:0] t_data = '0;
  int          n_cmp = 0, n_bad = 0;

  assign swdio_in = tgt_oe ? tgt_out : (swdio_oe ? swdio_out : 1'b1);

  always @(posedge swclk) begin
    if (slot - base >= 0 && slot - base < 64) begin
      cap_out[slot - base] = swdio_out;
      cap_oe[slot - base]  = swdio_oe;
    end
    slot = slot + 1;
  end

  always @(negedge swclk) begin
    int r;
    r = slot - base;
    tgt_oe = 1'b0;
    if (r >= 9 && r <= 11) begin
      tgt_oe = 1'b1; tgt_out = t_ack[r - 9];
    end else if (t_rd && t_ack == 3'b001 && r >= 12 && r <= 43) begin
      tgt_oe = 1'b1; tgt_out = t_data[r - 12];
    end else if (t_rd && t_ack == 3'b001 && r == 44) begin
      tgt_oe = 1'b1; tgt_out = (^t_data) ^ t_bad;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  int got_slots;
  logic [2:0] got_status;
  logic [31:0] got_rdata;

  task automatic xfer(input logic ap, input logic rd, input logic [1:0] addr,
                      input logic [31:0] wd, input logic [7:0] idle,
                      input logic [2:0] ack, input logic [31:0] td, input logic bad);
    t_ack = ack; t_rd = rd; t_data = td; t_bad = bad;
    base = slot;
    @(negedge clk);
    req_ap = ap; req_read = rd; req_addr = addr; req_wdata = wd; req_idle = idle;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
    got_status = rsp_status;
    got_rdata  = rsp_rdata;
    got_slots  = slot - base;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic check_pkt(input logic ap, input logic rd, input logic [1:0] a);
    logic [7:0] exp;
    logic [7:0] act;
    exp = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
    for (int i = 0; i < 8; i++) act[i] = cap_out[i];
    check("R1/R2", "request packet", {24'd0, act}, {24'd0, exp});
  endtask

  task automatic t_reset;
    check("R8", "swclk at reset", {31'd0, swclk}, 32'd0);
    check("R3", "idle drive", {30'd0, swdio_oe, swdio_out}, 32'd2);
    check("R9", "ready/valid at reset", {30'd0, req_ready, rsp_valid}, 32'd2);
  endtask

  task automatic t_dp_read;
    logic rel;
    xfer(1'b0, 1'b1, 2'b01, 32'h0, 8'd4, 3'b001, 32'hA5C3_0F12, 1'b0);
    check_pkt(1'b0, 1'b1, 2'b01);
    check("R5", "read status", {29'd0, got_status}, 32'd0);
    check("R5", "read data", got_rdata, 32'hA5C3_0F12);
    check("R7", "DP read slot count", got_slots, 46);
    rel = 1'b0;
    for (int i = 8; i <= 45; i++) rel = rel | cap_oe[i];
    check("R3", "host released on turnaround/ack/data", {31'd0, rel}, 32'd0);
  endtask

  task automatic t_ap_write;
    logic [31:0] wd;
    wd = 32'h1357_9BDF;
    xfer(1'b1, 1'b0, 2'b11, wd, 8'd3, 3'b001, 32'h0, 1'b0);
    check_pkt(1'b1, 1'b0, 2'b11);
    check("R6", "write status", {29'd0, got_status}, 32'd0);
    check("R6", "turnaround released", {31'd0, cap_oe[12]}, 32'd0);
    for (int i = 0; i < 32; i++)
      if (cap_out[13 + i] !== wd[i] || cap_oe[13 + i] !== 1'b1)
        check("R6", "write data bit", {31'd0, cap_out[13 + i]}, {31'd0, wd[i]});
    check("R6", "write parity", {31'd0, cap_out[45]}, {31'd0, ^wd});
    check("R7", "AP write slot count", got_slots, 49);
    for (int i = 46; i <= 48; i++)
      check("R7", "idle slot driven low", {30'd0, cap_oe[i], cap_out[i]}, 32'd2);
  endtask

  task automatic t_ap_read_gap;
    xfer(1'b1, 1'b1, 2'b10, 32'h0, 8'd2, 3'b001, 32'h8000_0001, 1'b0);
    check("R7", "AP read slot count", got_slots, 48);
    check("R5", "AP read data", got_rdata, 32'h8000_0001);
    check("R3", "host drives after read turnaround", {30'd0, cap_oe[46], cap_out[46]}, 32'd2);
  endtask

  task automatic t_dp_write_nogap;
    xfer(1'b0, 1'b0, 2'b00, 32'hFFFF_0000, 8'd5, 3'b001, 32'h0, 1'b0);
    check("R7", "DP write ignores idle hint", got_slots, 46);
    xfer(1'b1, 1'b0, 2'b00, 32'h0000_0003, 8'd0, 3'b001, 32'h0, 1'b0);
    check("R7", "AP write with zero hint", got_slots, 46);
  endtask

  task automatic t_bad_acks;
    xfer(1'b1, 1'b1, 2'b00, 32'h0, 8'd3, 3'b010, 32'hDEAD_BEEF, 1'b0);
    check("R4", "WAIT status", {29'd0, got_status}, 32'd1);
    check("R4", "WAIT slot count", got_slots, 13);
    check("R4", "WAIT turnaround released", {31'd0, cap_oe[12]}, 32'd0);
    xfer(1'b0, 1'b0, 2'b01, 32'h5, 8'd0, 3'b100, 32'h0, 1'b0);
    check("R4", "FAULT status", {29'd0, got_status}, 32'd2);
    check("R4", "FAULT slot count", got_slots, 13);
    xfer(1'b0, 1'b1, 2'b01, 32'h0, 8'd0, 3'b111, 32'h0, 1'b0);
    check("R4", "protocol error status", {29'd0, got_status}, 32'd3);
    check("R4", "protocol error slot count", got_slots, 13);
  endtask

  task automatic t_parity;
    xfer(1'b0, 1'b1, 2'b11, 32'h0, 8'd0, 3'b001, 32'h0F0F_1234, 1'b1);
    check("R5", "data parity error status", {29'd0, got_status}, 32'd4);
  endtask

  task automatic t_backpressure;
    t_ack = 3'b001; t_rd = 1'b0; base = slot;
    @(negedge clk);
    req_ap = 1'b0; req_read = 1'b0; req_addr = 2'b10; req_idle = 8'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
    for (int i = 0; i < 10; i++) @(negedge clk);
    check("R9", "response held under back-pressure", {30'd0, rsp_valid, req_ready}, 32'd2);
    check("R8", "swclk low while result pending", {31'd0, swclk}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9", "ready after response taken", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_divider;
    time t0, t1;
    clk_div = 8'd3;
    @(negedge clk);
    req_ap = 1'b0; req_read = 1'b0; req_idle = 8'd0; t_ack = 3'b001; t_rd = 1'b0;
    base = slot;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge swclk); t0 = $time;
    @(negedge swclk); t1 = $time;
    check("R8", "high half-period in cycles", 32'((t1 - t0) / 10), 32'd4);
    @(posedge swclk); t0 = $time;
    check("R8", "low half-period in cycles", 32'((t0 - t1) / 10), 32'd4);
    for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    clk_div = 8'd1;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dp_read();
    t_ap_write();
    t_ap_read_gap();
    t_dp_write_nogap();
    t_bad_acks();
    t_parity();
    t_backpressure();
    t_divider();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule